// File: doc/BRIEF.md
# ADC Parallel Result Read Port

This block sits between the conversion sequencer of an 8-bit sampling converter and a microprocessor-style parallel bus. It captures the newest conversion result when the busy indicator drops, and holds that byte until the next drop. It shows the byte on the bus whenever the host asserts both active-low strobes.

The strobes are sampled on the system clock, so the per-bit output enable is one cycle behind them. The enable stands in for pad three-state drivers: a low enable means high impedance. The block also does three other things:
- It exports the busy falling edge as a one-cycle end-of-conversion pulse, which a host can use as an interrupt request.
- It cancels any read in progress at the start of a conversion.
- It flags reads made while a conversion is running.

Reads keep working during long idle stretches with busy low, for example while the converter core is powered down.

Top module: `adc_rd_port`

## Requirements
- R1: After reset, the held result is zero. After reset, data_oe_o, data_o, eoc_o and read_invalid_o are all zero.
- R2: data_oe_o is all ones in the cycle after an edge that sampled cs_n_i=0 and rd_n_i=0, provided that edge does not also see a busy rising edge. It is all zeros in the cycle after an edge that sampled either strobe high.
- R3: While data_oe_o is all ones, data_o equals the held result, with bit i of the result on bit i. While data_oe_o is zero, data_o is zero.
- R4: The held result takes result_i only at the clock edge that first samples busy_i low after sampling it high. Changes on result_i at any other time have no effect on the held result.
- R5: eoc_o is high for exactly one cycle, starting at the edge where busy_i is first sampled low after being high.
- R6: At the edge that first samples busy_i high after it was low, the read port resets: data_oe_o is zero for the following cycle even if both strobes are low.
- R7: read_invalid_o is high in the cycle after an edge that sampled both strobes low together with busy_i high. Otherwise it is low.
- R8: Reads do not change the held result. Repeated reads with busy_i held low return the same byte.
- R9: The result is straight binary: every code 0 to 255 loaded at end of conversion reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Conversion in progress, from the sequencer |
| result_i | input | 8 | New conversion result byte |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| data_o | output | 8 | Parallel data bus |
| data_oe_o | output | 8 | Per-bit output enable; zero means high impedance |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| read_invalid_o | output | 1 | A read was made while busy was high |

## Verification
The bench loads every one of the 256 codes and reads each one back. During each read it moves result_i, so a design that loaded on busy level instead of on the falling edge would return the wrong byte. It starts conversions with both strobes already low. A port that skipped the reset on the busy rise would keep driving in that cycle, and one that did not flag the read would leave read_invalid_o low. Reads with only one strobe low catch an OR where an AND belongs. Back-to-back reads catch a register that reads disturb, and the end-of-conversion pulse is checked for a width of exactly one cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/adc_busy_edge.sv
module adc_busy_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic rise_o,
  output logic fall_o,
  output logic eoc_o
);
  logic busy_q, busy_d;
  logic eoc_q, eoc_d;

  always_comb begin
    busy_d = busy_i;
    eoc_d  = busy_q & ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      eoc_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      eoc_q  <= eoc_d;
    end
  end

  assign rise_o = busy_i & ~busy_q;
  assign fall_o = busy_q & ~busy_i;
  assign eoc_o  = eoc_q;

  // R5: the end-of-conversion pulse lasts a single cycle
  a_r5_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |=> !eoc_o);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load_i) code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/adc_bus_gate.sv
module adc_bus_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n_i,
  input  logic         rd_n_i,
  input  logic         busy_i,
  input  logic         abort_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o,
  output logic         invalid_o
);
  logic sel;
  logic oe_q, oe_d;
  logic inv_q, inv_d;

  always_comb begin
    sel   = ~cs_n_i & ~rd_n_i;
    oe_d  = sel & ~abort_i;
    inv_d = sel & busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      inv_q <= inv_d;
    end
  end

  assign oe_o      = {W{oe_q}};
  assign data_o    = oe_q ? code_i : '0;
  assign invalid_o = inv_q;

  // R2: either strobe high releases the bus on the next cycle
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |=> (oe_o == '0));
  // R6: a conversion start resets the read port
  a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (oe_o == '0));
  // R7: the invalid flag only follows a sample taken while busy
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> $past(busy_i));
endmodule

// File: rtl/adc_rd_port.sv
module adc_rd_port
  import adc_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy_i,
  input  code_t       result_i,
  input  logic        cs_n_i,
  input  logic        rd_n_i,
  output code_t       data_o,
  output code_t       data_oe_o,
  output logic        eoc_o,
  output logic        read_invalid_o
);
  logic  busy_rise, busy_fall;
  code_t held;

  adc_busy_edge i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (busy_i),
    .rise_o (busy_rise),
    .fall_o (busy_fall),
    .eoc_o  (eoc_o)
  );

  adc_result_hold #(.W(CODE_W)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (busy_fall),
    .code_i (result_i),
    .code_o (held)
  );

  adc_bus_gate #(.W(CODE_W)) i_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .rd_n_i    (rd_n_i),
    .busy_i    (busy_i),
    .abort_i   (busy_rise),
    .code_i    (held),
    .data_o    (data_o),
    .oe_o      (data_oe_o),
    .invalid_o (read_invalid_o)
  );

  // R4: the held result moves only at a busy falling edge
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_fall |=> $stable(held));
  // R3: a bus that is not enabled reads as zero
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o == '0) |-> (data_o == '0));
  // R5: a pulse appears only after busy was seen falling
  a_r5_eoc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> $past(busy_fall));
endmodule

// File: tb/test_adc_rd_port.sv
module test_adc_rd_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] res = 8'h00;
  logic       cs_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] data, oe;
  logic       eoc, inval;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_rd_port i_adc_rd_port (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .result_i(res),
    .cs_n_i(cs_n), .rd_n_i(rd_n), .data_o(data), .data_oe_o(oe),
    .eoc_o(eoc), .read_invalid_o(inval)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run one conversion ending with the given code; check the EOC pulse.
  task automatic convert(input logic [7:0] code);
    busy = 1'b1; step();
    step();
    res = code; busy = 1'b0; step();
    chk("R5 eoc high", {7'd0, eoc}, 8'd1);
    step();
    chk("R5 eoc one cycle", {7'd0, eoc}, 8'd0);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    done = 1'b1;
  end

  initial begin
    step(); step();
    chk("R1 oe", oe, 8'h00);
    chk("R1 data", data, 8'h00);
    chk("R1 eoc", {7'd0, eoc}, 8'd0);
    chk("R1 invalid", {7'd0, inval}, 8'd0);
    rst_n = 1'b1; step();
    cs_n = 1'b0; rd_n = 1'b0; step();
    chk("R1 held zero oe", oe, 8'hFF);
    chk("R1 held zero data", data, 8'h00);
    cs_n = 1'b1; rd_n = 1'b1; step();

    // R9 sweep all codes, R4 result_i moving during read
    for (int c = 0; c < 256; c++) begin
      convert(c[7:0]);
      res = ~c[7:0];
      cs_n = 1'b0; rd_n = 1'b0; step();
      chk("R2 oe on", oe, 8'hFF);
      chk("R9 code", data, c[7:0]);
      chk("R7 no flag", {7'd0, inval}, 8'd0);
      step();
      chk("R4 result_i ignored", data, c[7:0]);
      cs_n = 1'b1; rd_n = 1'b1; step();
      chk("R3 quiet oe", oe, 8'h00);
      chk("R3 quiet data", data, 8'h00);
    end

    // single strobes
    cs_n = 1'b0; rd_n = 1'b1; step();
    chk("R2 cs only", oe, 8'h00);
    cs_n = 1'b1; rd_n = 1'b0; step();
    chk("R2 rd only", oe, 8'h00);
    rd_n = 1'b1; step();

    // R8 repeated reads during a long idle period
    convert(8'hA5);
    for (int k = 0; k < 20; k++) step();
    for (int k = 0; k < 5; k++) begin
      cs_n = 1'b0; rd_n = 1'b0; step();
      chk("R8 repeat read", data, 8'hA5);
      cs_n = 1'b1; rd_n = 1'b1; step();
      chk("R8 released", oe, 8'h00);
    end

    // R6/R7 conversion starts during a read
    cs_n = 1'b0; rd_n = 1'b0; step();
    chk("R6 pre oe", oe, 8'hFF);
    busy = 1'b1; res = 8'h3C; step();
    chk("R6 abort oe", oe, 8'h00);
    chk("R7 flag", {7'd0, inval}, 8'd1);
    step();
    chk("R7 flag held", {7'd0, inval}, 8'd1);
    chk("R4 no load while busy", data, 8'hA5);
    busy = 1'b0; step();
    chk("R7 flag clear", {7'd0, inval}, 8'd0);
    chk("R4 loaded at fall", data, 8'h3C);
    chk("R5 eoc with read", {7'd0, eoc}, 8'd1);
    cs_n = 1'b1; rd_n = 1'b1; step();
    chk("R3 quiet end", data, 8'h00);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule